// File: doc/BRIEF.md
# UART with Error-Tagged Receive FIFO

An asynchronous serial transceiver that turns bytes written by a host into framed serial characters and turns incoming characters back into bytes. A 16-bit divisor sets the bit rate as clock / (16 x divisor). With a divisor of 1, a 50 MHz module clock gives 3.125 Mbps. Transmit bytes wait in a 16-entry queue. Received characters land in a 16-entry queue whose entries are 12 bits wide. Each entry carries its data byte together with the line errors seen while that byte arrived, so software can tell exactly which byte went wrong.

The host reaches the block through a small register write port and a pop strobe for the receive queue. Register 0 pushes a transmit byte. Register 1 holds the divisor. Register 2 holds the queue thresholds and the framing options. Register 3 holds the interrupt enables and the clear strobes for the latched sources. Four interrupt sources merge into a single `irq` line: receive level, transmit level, modem status change and receive error.

Top module: `uart_tagged`

## Requirements
- R1: After reset, `txd` is high, `irq` is low, `rx_empty` is high and `tx_full` is low. The divisor is 1, the control register is 0 and all interrupt enables are 0.
- R2: A character is sent and received as one low start bit, 8 data bits LSB first, an optional parity bit, then stop bits. Each bit lasts 16 x divisor clocks. Control bit 12 selects two stop bits on transmit; the receiver checks only the first stop bit.
- R3: A write to register 0 pushes `reg_wdata[7:0]`. One byte can sit in the shifter with 16 more queued behind it. A write while 16 are queued is dropped, and `tx_full` is high while 16 are queued.
- R4: A receive entry holds data in bits 7:0, framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. Entries leave in arrival order, one per `rx_pop` cycle.
- R5: Control bit 10 enables parity, and bit 11 selects odd parity (1) or even parity (0). The transmitter sends the matching bit. The receiver sets bit 9 when the received parity bit disagrees.
- R6: A first stop bit sampled low sets bit 8 of the entry.
- R7: A character whose data bits, parity bit (if enabled) and stop bit are all low is stored as data 0 with bits 10 and 8 set. The receiver then waits for the line to go high before it looks for a new start bit.
- R8: A character that completes while 16 entries are stored is discarded, and bit 11 is set on the most recently stored entry.
- R9: The receive source is active when the stored entry count is at or above control bits 4:0. The transmit source is active when the queued byte count is at or below control bits 9:5.
- R10: `irq` is high exactly when some source is active and its enable in register 3 is set: bit 0 for receive, bit 1 for transmit, bit 2 for modem status and bit 3 for receive error.
- R11: A low on `rxd` shorter than half a bit is not taken as a start bit and stores nothing.
- R12: A `modem_chg` pulse latches the modem source, and writing register 3 with bit 8 set clears it. Storing an entry with any error flag, or an overrun, latches the error source; writing register 3 with bit 9 set clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 TX data, 1 divisor, 2 control, 3 enables/clears |
| reg_wdata | input | 16 | Register write data |
| rx_pop | input | 1 | Remove the entry at the head of the receive queue |
| rx_rdata | output | 12 | Entry at the head of the receive queue |
| rx_empty | output | 1 | Receive queue holds no entry |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| modem_chg | input | 1 | Pulse marking a modem status change |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `modem_chg` is a single-cycle pulse and that the divisor and framing options stay fixed while a character is on either line. They also assume that the serial input is either the block's own output or a clean frame whose bit timing matches the programmed divisor. The stimulus respects these assumptions. It changes register 1 and register 2 only after the scoreboard has drained and the line has been idle for several bit times. It drives hand-built frames bit by bit at exactly 16 x divisor clocks per bit. Corrupted frames, long breaks and short glitches are produced only through `rxd` and never by touching internal state.

// File: rtl/uart_tagged.sv
module uart_tagged #(
  parameter int DEPTH = 16,
  parameter int DIVW  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        rx_pop,
  output logic [11:0] rx_rdata,
  output logic        rx_empty,
  output logic        tx_full,
  input  logic        modem_chg,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam int PE_B = 2 * CW;
  localparam int PO_B = 2 * CW + 1;
  localparam int TS_B = 2 * CW + 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_WAITHI} rx_st_t;

  logic [DIVW-1:0] div_q, div_m1;
  logic [CW-1:0]   rx_lvl, tx_lvl;
  logic            par_en, par_odd, two_stop;
  logic [3:0]      mask_q;
  logic            modem_src, err_src;

  wire w_tx  = reg_we && reg_addr == 2'd0;
  wire w_div = reg_we && reg_addr == 2'd1;
  wire w_ctl = reg_we && reg_addr == 2'd2;
  wire w_msk = reg_we && reg_addr == 2'd3;

  assign div_m1 = (div_q == '0) ? '0 : div_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIVW'(1);
      rx_lvl <= '0; tx_lvl <= '0;
      par_en <= 1'b0; par_odd <= 1'b0; two_stop <= 1'b0;
      mask_q <= '0;
    end else begin
      if (w_div) div_q <= reg_wdata[DIVW-1:0];
      if (w_ctl) begin
        rx_lvl   <= reg_wdata[CW-1:0];
        tx_lvl   <= reg_wdata[2*CW-1:CW];
        par_en   <= reg_wdata[PE_B];
        par_odd  <= reg_wdata[PO_B];
        two_stop <= reg_wdata[TS_B];
      end
      if (w_msk) mask_q <= reg_wdata[3:0];
    end
  end

  // transmit queue and shifter
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_busy;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left, tx_sub;
  logic [DIVW-1:0] tx_bc;

  wire tx_pop  = !tx_busy && tx_cnt != '0;
  wire tx_push = w_tx && tx_cnt != FULL;
  wire [7:0]  tx_byte  = tx_mem[tx_rp];
  wire        tx_par   = ^tx_byte ^ par_odd;
  wire [11:0] tx_frame = par_en ? {2'b11, tx_par, tx_byte, 1'b0} : {3'b111, tx_byte, 1'b0};

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_sub <= '0; tx_bc <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_frame;
      tx_left <= 4'd10 + {3'b0, par_en} + {3'b0, two_stop};
      tx_sub  <= '0;
      tx_bc   <= div_m1;
    end else if (tx_busy) begin
      if (tx_bc == '0) begin
        tx_bc  <= div_m1;
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == 4'd15) begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end
      end else begin
        tx_bc <= tx_bc - 1'b1;
      end
    end
  end

  assign txd     = tx_busy ? tx_sh[0] : 1'b1;
  assign tx_full = tx_cnt == FULL;

  // receiver
  logic [1:0]  rx_sy;
  rx_st_t      rx_st;
  logic [DIVW-1:0] rx_bc;
  logic [3:0]  rx_sub, rx_bit;
  logic [8:0]  rx_sh;

  wire       rxs     = rx_sy[1];
  wire       rx_tick = rx_bc == '0;
  wire [3:0] rx_last = par_en ? 4'd9 : 4'd8;
  wire       rx_done = rx_st == RX_DATA && rx_tick && rx_sub == 4'd15 && rx_bit == rx_last;
  wire       fe  = !rxs;
  wire       pe  = par_en && (rx_sh[8] != (^rx_sh[7:0] ^ par_odd));
  wire       brk = rx_sh[7:0] == 8'h00 && !rxs && !(par_en && rx_sh[8]);
  wire [11:0] rx_entry = {1'b0, brk, pe, fe, rx_sh[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sy <= 2'b11; rx_st <= RX_IDLE; rx_bc <= '0;
      rx_sub <= '0; rx_bit <= '0; rx_sh <= '0;
    end else begin
      rx_sy <= {rx_sy[0], rxd};
      case (rx_st)
        RX_IDLE: if (!rxs) begin
          rx_st <= RX_START; rx_bc <= div_m1; rx_sub <= '0;
        end
        RX_START: if (rx_tick) begin
          rx_bc  <= div_m1;
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == 4'd7) begin
            if (!rxs) begin rx_st <= RX_DATA; rx_sub <= '0; rx_bit <= '0; end
            else rx_st <= RX_IDLE;
          end
        end else rx_bc <= rx_bc - 1'b1;
        RX_DATA: if (rx_tick) begin
          rx_bc  <= div_m1;
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == 4'd15) begin
            if (rx_bit == rx_last) rx_st <= rxs ? RX_IDLE : RX_WAITHI;
            else begin rx_sh[rx_bit] <= rxs; rx_bit <= rx_bit + 1'b1; end
          end
        end else rx_bc <= rx_bc - 1'b1;
        default: if (rxs) rx_st <= RX_IDLE;
      endcase
    end
  end

  // receive queue
  logic [11:0]   rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;

  wire rx_push  = rx_done;
  wire rx_store = rx_push && rx_cnt != FULL;
  wire rx_ovr   = rx_push && rx_cnt == FULL;
  wire rx_take  = rx_pop && rx_cnt != '0;

  always_ff @(posedge clk) begin
    if (rx_store) rx_mem[rx_wp] <= rx_entry;
    if (rx_ovr)   rx_mem[rx_wp - 1'b1][11] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_store) rx_wp <= rx_wp + 1'b1;
      if (rx_take)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_store) - CW'(rx_take);
    end
  end

  assign rx_rdata = rx_mem[rx_rp];
  assign rx_empty = rx_cnt == '0;

  // interrupt sources
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modem_src <= 1'b0; err_src <= 1'b0;
    end else begin
      if (modem_chg) modem_src <= 1'b1;
      else if (w_msk && reg_wdata[8]) modem_src <= 1'b0;
      if ((rx_push && (pe || fe || brk)) || rx_ovr) err_src <= 1'b1;
      else if (w_msk && reg_wdata[9]) err_src <= 1'b0;
    end
  end

  wire [3:0] src = {err_src, modem_src, tx_cnt <= tx_lvl, rx_cnt >= rx_lvl};
  assign irq = |(src & mask_q);
endmodule

// File: rtl/uart_tagged_chk.sv
module uart_tagged_chk #(
  parameter int CW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          rx_pop,
  input logic          modem_chg,
  input logic          txd,
  input logic          irq,
  input logic [3:0]    mask_q,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_pop,
  input logic          tx_busy,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_push,
  input logic          modem_src
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);
  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && tx_cnt == FULL && !tx_pop) |=> tx_cnt == FULL);
  p_rx_hold_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == FULL && !rx_pop) |=> rx_cnt == FULL);
  p_rx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL);
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == 4'h0 |-> !irq);
  p_modem_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    modem_chg |=> modem_src);
endmodule

bind uart_tagged uart_tagged_chk #(.CW(CW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .rx_pop(rx_pop), .modem_chg(modem_chg), .txd(txd), .irq(irq),
  .mask_q(mask_q), .tx_cnt(tx_cnt), .tx_pop(tx_pop), .tx_busy(tx_busy),
  .rx_cnt(rx_cnt), .rx_push(rx_push), .modem_src(modem_src)
);

// File: tb/uart_tagged_tb_top.sv
module uart_tagged_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        rx_pop;
  logic [11:0] rx_rdata;
  logic        rx_empty, tx_full, modem_chg, txd, irq;
  logic        loop, bench_rxd, mon_en;
  wire         rxd = loop ? txd : bench_rxd;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";
  logic [11:0] exp_q[$];

  always #2 clk = ~clk;

  uart_tagged dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_empty(rx_empty), .tx_full(tx_full), .modem_chg(modem_chg),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input int rxl, input int txl,
                                      input bit pe, input bit po, input bit ts);
    return {3'b0, ts, po, pe, 5'(txl), 5'(rxl)};
  endfunction

  task automatic send_byte(input logic [7:0] b, input logic [11:0] e);
    exp_q.push_back(e);
    wr(2'd0, {8'h00, b});
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (80) @(negedge clk);
  endtask

  task automatic send_raw(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      bench_rxd = bits[i];
      repeat (16) @(negedge clk);
    end
    bench_rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    rx_pop = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && !rx_empty) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected entry"}, rx_rdata, 32'hFFFF);
        else chk(cur_req, rx_rdata, exp_q.pop_front());
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lowrun;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    loop = 1'b1; bench_rxd = 1'b1; modem_chg = 1'b0; mon_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 irq", irq, 0);
    chk("R1 rx_empty", rx_empty, 1); chk("R1 tx_full", tx_full, 0);

    // R2 R4: plain loopback
    cur_req = "R2/R4 loopback";
    send_byte(8'h55, 12'h055); send_byte(8'hA3, 12'h0A3);
    send_byte(8'h00, 12'h000); send_byte(8'hFF, 12'h0FF);
    drain();
    cur_req = "R2 two stop";
    wr(2'd2, ctl(0, 0, 0, 0, 1));
    send_byte(8'h3C, 12'h03C); send_byte(8'hC3, 12'h0C3);
    drain();

    // R5: parity loopback
    cur_req = "R5 even";
    wr(2'd2, ctl(0, 0, 1, 0, 0));
    send_byte(8'h81, 12'h081); send_byte(8'h7E, 12'h07E);
    drain();
    cur_req = "R5 odd";
    wr(2'd2, ctl(0, 0, 1, 1, 0));
    send_byte(8'h01, 12'h001); send_byte(8'hFE, 12'h0FE);
    drain();

    // bench-driven frames
    loop = 1'b0;
    cur_req = "R5 bad even parity";
    wr(2'd2, ctl(0, 0, 1, 0, 0));
    exp_q.push_back(12'h203);
    send_raw({1'b1, 1'b1, 8'h03, 1'b0}, 11);
    drain();
    cur_req = "R5 good odd parity";
    wr(2'd2, ctl(0, 0, 1, 1, 0));
    exp_q.push_back(12'h003);
    send_raw({1'b1, 1'b1, 8'h03, 1'b0}, 11);
    drain();
    cur_req = "R6 framing";
    wr(2'd2, ctl(0, 0, 0, 0, 0));
    exp_q.push_back(12'h15A);
    send_raw({2'b00, 1'b0, 8'h5A, 1'b0}, 10);
    drain();
    cur_req = "R7 break";
    exp_q.push_back(12'h500);
    bench_rxd = 1'b0;
    repeat (12 * 16) @(negedge clk);
    bench_rxd = 1'b1;
    repeat (40) @(negedge clk);
    drain();
    cur_req = "R11 glitch";
    bench_rxd = 1'b0;
    repeat (4) @(negedge clk);
    bench_rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R11 glitch stores nothing", rx_empty, 1);
    loop = 1'b1;

    // R2: bit length scales with divisor
    cur_req = "R2 divisor 3";
    wr(2'd1, 16'd3);
    send_byte(8'h01, 12'h001);
    for (int i = 0; i < 200 && txd; i++) @(negedge clk);
    lowrun = 0;
    while (!txd && lowrun < 1000) begin lowrun++; @(negedge clk); end
    chk("R2 start bit length", lowrun, 48);
    drain();
    wr(2'd1, 16'd1);

    // R3: burst into the transmit queue
    cur_req = "R3 burst";
    for (int i = 0; i < 20; i++) begin
      if (i < 17) exp_q.push_back(12'(8'h10 + i));
      wr(2'd0, 16'(8'h10 + i));
    end
    chk("R3 tx_full after burst", tx_full, 1);
    drain();
    chk("R3 tx_full cleared", tx_full, 0);

    // R8: overrun with scoreboard paused
    mon_en = 1'b0;
    for (int i = 0; i < 17; i++) wr(2'd0, 16'(8'h40 + i));
    repeat (3500) @(negedge clk);
    chk("R8 rx queue not empty", rx_empty, 0);

    // R9 R10 R12: interrupt sources with 16 entries held
    wr(2'd2, ctl(16, 0, 0, 0, 0)); wr(2'd3, 16'h0001);
    chk("R9 rx at level", irq, 1);
    wr(2'd2, ctl(17, 0, 0, 0, 0));
    chk("R9 rx below level", irq, 0);
    wr(2'd3, 16'h0002);
    chk("R9 tx at level", irq, 1);
    wr(2'd3, 16'h0004);
    chk("R12 modem idle", irq, 0);
    modem_chg = 1'b1; @(negedge clk); modem_chg = 1'b0;
    chk("R12 modem latched", irq, 1);
    wr(2'd3, 16'h0104);
    chk("R12 modem cleared", irq, 0);
    wr(2'd3, 16'h0008);
    chk("R12 error latched", irq, 1);
    wr(2'd3, 16'h0208);
    chk("R12 error cleared", irq, 0);
    wr(2'd3, 16'h0000);
    chk("R10 all disabled", irq, 0);
    wr(2'd3, 16'h000F);
    chk("R10 combined", irq, 1);
    wr(2'd3, 16'h0000);

    cur_req = "R8 overrun";
    for (int i = 0; i < 15; i++) exp_q.push_back(12'(8'h40 + i));
    exp_q.push_back(12'h84F);
    mon_en = 1'b1;
    drain();
    chk("R8 drained", rx_empty, 1);
    chk("R8 scoreboard empty", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule